// File: doc/BRIEF.md
# Power-Management Event, Control and Timer Register Block

This block is the I/O-mapped event and timer section of a system power-management controller. A host reaches it through a 64-byte I/O window. The window's base address and a decode-enable bit come from configuration-space inputs. The window holds four registers:

- a 16-bit event status register, with write-one-to-clear bits set by hardware events;
- a 16-bit event enable register;
- a 16-bit control register, which holds the interrupt-routing enable and the sleep fields;
- a free-running timer that is read as a 32-bit value.

The block drives a level-sensitive system control interrupt (SCI) for the operating system. The SCI is high while one of four enabled events is pending. The four events are the real-time-clock alarm, the power button, the global lock release and timer overflow.

The timer counts a tick-enable input that stands in for the 3.579545 MHz power-management clock. Each time the timer's top bit changes value, the timer event bit is set. The SCI level is recomputed only when the status register is written, when the enable register is written, or when the timer overflows. A hardware event that arrives between those moments sets its status bit, but it does not move the SCI until the next such moment. A write of the sleep-enable bit in the control register produces a one-cycle sleep request that carries the 3-bit sleep type.

Top module: `pm1_evt_timer`

## Requirements
- R1: An access hits the window only while `cfg_ctrl[0]` is 1 and `io_addr[15:6]` equals `cfg_base[15:6]`. `cfg_base` bits 5:0 and 31:16 are ignored. Outside the window, or while decode is disabled, `io_rdata` is 0 and writes change nothing. `io_rdata` is also 0 whenever `io_rd` is low.
- R2: Only `io_addr[3:0]` selects a register inside the window. For example, window offset 0x12 reaches the same register as offset 0x02.
- R3: The status register sits at offset 0x0 and is accessed 16 bits wide (`io_wide`=0). It implements bit 0 (timer), bit 5 (global lock, set by `evt_gbl`), bit 8 (power button, set by `evt_pwrbtn`) and bit 10 (RTC, set by `evt_rtc`). All other bits read 0. Writing 1 to a bit clears it and writing 0 leaves it unchanged. A set and a clear in the same cycle leave the bit set.
- R4: The enable register sits at offset 0x2 and is a 16-bit read/write register holding all 16 bits.
- R5: The SCI, when updated, takes the value of the OR over bits 0, 5, 8 and 10 of (status AND enable), using the register values after that cycle's updates. The SCI is registered.
- R6: The SCI is updated only in a cycle with a 16-bit write to offset 0x0, a 16-bit write to offset 0x2, or a timer overflow. In any other cycle it holds its value, even if an event sets a status bit.
- R7: The timer is `TMR_W` bits wide (24 by default). It increments by one in each cycle with `tick` high and wraps at its maximum. A 32-bit read (`io_wide`=1) at offset 0x8 returns its value zero-extended.
- R8: A tick that changes timer bit `TMR_W-1` sets status bit 0. This happens in both directions: the rising change and the wrap to zero.
- R9: The control register sits at offset 0x4. It stores bit 0 (SCI enable) and bits 12:10 (sleep type). Bit 13 (sleep enable) always reads 0. A write with bit 13 set pulses `slp_req` for one cycle, starting in the cycle after the write, with the written sleep type on `slp_typ`.
- R10: A 16-bit read at any offset other than 0x0, 0x2 or 0x4 returns 0. A 32-bit read at any offset other than 0x8 returns 0. 32-bit writes, and 16-bit writes to other offsets, have no effect.
- R11: Reset (`rst_n` low) clears status, enable and control, sets the timer to 0, and drives `sci` and `slp_req` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | 32 | Configuration dword holding the window base in bits 15:6 |
| cfg_ctrl | input | 8 | Configuration byte; bit 0 enables window decode |
| io_addr | input | 16 | I/O address |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wide | input | 1 | 1 for a 32-bit access, 0 for a 16-bit access |
| io_wdata | input | 32 | Write data |
| io_rdata | output | 32 | Combinational read data |
| tick | input | 1 | Timer advance enable |
| evt_rtc | input | 1 | RTC alarm event |
| evt_pwrbtn | input | 1 | Power button event |
| evt_gbl | input | 1 | Global lock release event |
| sci | output | 1 | System control interrupt level |
| slp_req | output | 1 | One-cycle sleep request |
| slp_typ | output | 3 | Sleep type stored in the control register |

## Verification
The bench sets an event while nothing else happens and checks that the SCI stays put until the next write. A design that drove the SCI combinationally would raise it too early.

It runs the timer across both changes of its top bit. A design that detected only the carry out would miss the rising change. A design that compared against the wrong bit would set the timer event at the wrong count.

It probes aliased offsets, 16-bit reads of the timer offset and 32-bit writes. A decoder that used too many address bits, or let width-mismatched accesses through, would return or store data it should not. It also writes a clear and raises an event in the same cycle. A design where the clear wins would lose that event.

// File: rtl/pm1_evt_timer.sv
module pm1_evt_timer #(
  parameter int TMR_W = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] cfg_base,
  input  logic [7:0]  cfg_ctrl,
  input  logic [15:0] io_addr,
  input  logic        io_rd,
  input  logic        io_wr,
  input  logic        io_wide,
  input  logic [31:0] io_wdata,
  output logic [31:0] io_rdata,
  input  logic        tick,
  input  logic        evt_rtc,
  input  logic        evt_pwrbtn,
  input  logic        evt_gbl,
  output logic        sci,
  output logic        slp_req,
  output logic [2:0]  slp_typ
);
  localparam logic [15:0] EVT_MASK = 16'h0521;
  localparam int TOP = TMR_W - 1;

  logic [15:0]      sts, en, sts_n, en_n, sts_set, sts_clr;
  logic [TMR_W-1:0] tmr, tmr_n;
  logic             sci_en;
  logic             hit, wr16, wr_sts, wr_en, wr_cnt, ovf;
  logic [3:0]       off;

  assign hit    = cfg_ctrl[0] && (io_addr[15:6] == cfg_base[15:6]);
  assign off    = io_addr[3:0];
  assign wr16   = io_wr && hit && !io_wide;
  assign wr_sts = wr16 && (off == 4'h0);
  assign wr_en  = wr16 && (off == 4'h2);
  assign wr_cnt = wr16 && (off == 4'h4);

  assign tmr_n = tick ? tmr + 1'b1 : tmr;
  assign ovf   = tick && (tmr_n[TOP] != tmr[TOP]);

  always_comb begin
    sts_set     = '0;
    sts_set[0]  = ovf;
    sts_set[5]  = evt_gbl;
    sts_set[8]  = evt_pwrbtn;
    sts_set[10] = evt_rtc;
  end

  assign sts_clr = wr_sts ? io_wdata[15:0] : 16'h0;
  assign sts_n   = ((sts & ~sts_clr) | sts_set) & EVT_MASK;
  assign en_n    = wr_en ? io_wdata[15:0] : en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts     <= '0;
      en      <= '0;
      tmr     <= '0;
      sci     <= 1'b0;
      sci_en  <= 1'b0;
      slp_typ <= '0;
      slp_req <= 1'b0;
    end else begin
      sts     <= sts_n;
      en      <= en_n;
      tmr     <= tmr_n;
      slp_req <= wr_cnt && io_wdata[13];
      if (wr_sts || wr_en || ovf)
        sci <= |(sts_n & en_n & EVT_MASK);
      if (wr_cnt) begin
        sci_en  <= io_wdata[0];
        slp_typ <= io_wdata[12:10];
      end
    end
  end

  always_comb begin
    io_rdata = '0;
    if (io_rd && hit) begin
      if (io_wide) begin
        if (off == 4'h8) io_rdata = 32'(tmr);
      end else begin
        unique case (off)
          4'h0:    io_rdata = {16'h0, sts};
          4'h2:    io_rdata = {16'h0, en};
          4'h4:    io_rdata = {16'h0, 3'b000, slp_typ, 9'h0, sci_en};
          default: io_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/pm1_evt_timer_chk.sv
module pm1_evt_timer_chk #(
  parameter int TMR_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hit,
  input logic [15:0]      io_addr,
  input logic             io_rd,
  input logic             io_wr,
  input logic             io_wide,
  input logic [31:0]      io_wdata,
  input logic [31:0]      io_rdata,
  input logic             tick,
  input logic [15:0]      sts,
  input logic [15:0]      en,
  input logic [TMR_W-1:0] tmr,
  input logic             sci,
  input logic             slp_req
);
  a_r5_sci_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    sci |-> |(sts & en & 16'h0521));

  a_r7_tmr_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(tick)) |-> tmr == TMR_W'($past(tmr) + 1'b1));

  a_r7_tmr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(tick)) |-> $stable(tmr));

  a_r8_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && tmr[TMR_W-1] != $past(tmr[TMR_W-1])) |-> sts[0]);

  a_r9_slp_cause: assert property (@(posedge clk) disable iff (!rst_n)
    slp_req |-> $past(rst_n && io_wr && hit && !io_wide &&
                      io_addr[3:0] == 4'h4 && io_wdata[13]));

  a_r10_wide_wr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && io_wr && io_wide) |-> $stable(en));

  a_r1_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_rd && hit) |-> io_rdata == 32'h0);
endmodule

bind pm1_evt_timer pm1_evt_timer_chk #(.TMR_W(TMR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hit(hit), .io_addr(io_addr), .io_rd(io_rd),
  .io_wr(io_wr), .io_wide(io_wide), .io_wdata(io_wdata), .io_rdata(io_rdata),
  .tick(tick), .sts(sts), .en(en), .tmr(tmr), .sci(sci), .slp_req(slp_req)
);

// File: tb/pm1_evt_timer_tb.sv
module pm1_evt_timer_tb;
  localparam int TW = 8;
  logic clk = 0, rst_n = 0;
  logic [31:0] cfg_base = 32'h1234_B02A;
  logic [7:0]  cfg_ctrl = 8'h01;
  logic [15:0] io_addr = 0;
  logic io_rd = 0, io_wr = 0, io_wide = 0, tick = 0;
  logic evt_rtc = 0, evt_pwrbtn = 0, evt_gbl = 0;
  logic [31:0] io_wdata = 0, io_rdata;
  logic sci, slp_req;
  logic [2:0] slp_typ;
  int errors = 0, checks = 0;

  // Reference state, kept from the requirements
  logic [15:0] m_sts = 0, m_en = 0;
  logic [TW-1:0] m_tmr = 0;
  logic m_sci = 0, m_scien = 0, m_req = 0;
  logic [2:0] m_typ = 0;

  pm1_evt_timer #(.TMR_W(TW)) u_dut (.*);

  always #4 clk = ~clk;

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic logic m_hit();
    return cfg_ctrl[0] && io_addr[15:6] == cfg_base[15:6];
  endfunction

  function automatic logic [31:0] m_rd();
    if (!(io_rd && m_hit())) return 0;
    if (io_wide) return (io_addr[3:0] == 4'h8) ? 32'(m_tmr) : 0;
    case (io_addr[3:0])
      4'h0: return {16'h0, m_sts};
      4'h2: return {16'h0, m_en};
      4'h4: return {16'h0, 3'b000, m_typ, 9'h0, m_scien};
      default: return 0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: check read data, advance reference, check registered outputs
  task automatic cyc(string req);
    logic w16, ws, we, ovf;
    logic [TW-1:0] nt;
    logic [15:0] ns, ne, set;
    #1;
    if (io_rd) chk({req, " rdata"}, io_rdata, m_rd());
    w16 = io_wr && m_hit() && !io_wide;
    ws = w16 && io_addr[3:0] == 4'h0;
    we = w16 && io_addr[3:0] == 4'h2;
    nt = tick ? m_tmr + 1'b1 : m_tmr;
    ovf = tick && nt[TW-1] != m_tmr[TW-1];
    set = 0; set[0] = ovf; set[5] = evt_gbl; set[8] = evt_pwrbtn; set[10] = evt_rtc;
    ns = ((m_sts & ~(ws ? io_wdata[15:0] : 16'h0)) | set) & 16'h0521;
    ne = we ? io_wdata[15:0] : m_en;
    if (ws || we || ovf) m_sci = |(ns & ne & 16'h0521);
    m_req = w16 && io_addr[3:0] == 4'h4 && io_wdata[13];
    if (w16 && io_addr[3:0] == 4'h4) begin
      m_scien = io_wdata[0]; m_typ = io_wdata[12:10];
    end
    m_sts = ns; m_en = ne; m_tmr = nt;
    @(negedge clk);
    chk("R5 R6 sci", {31'h0, sci}, {31'h0, m_sci});
    chk("R9 slp_req", {31'h0, slp_req}, {31'h0, m_req});
    if (m_req) chk("R9 slp_typ", {29'h0, slp_typ}, {29'h0, m_typ});
  endtask

  task automatic idle();
    io_rd = 0; io_wr = 0; io_wide = 0; tick = 0;
    evt_rtc = 0; evt_pwrbtn = 0; evt_gbl = 0;
  endtask

  task automatic acc(string req, logic wr, logic wide, logic [15:0] a, logic [31:0] d);
    idle(); io_addr = a; io_wr = wr; io_rd = !wr; io_wide = wide; io_wdata = d;
    cyc(req);
    idle();
  endtask

  localparam logic [15:0] B = 16'hB000;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    acc("R11 sts", 0, 0, B + 0, 0);
    acc("R11 en", 0, 0, B + 2, 0);
    acc("R11 cnt", 0, 0, B + 4, 0);
    acc("R11 tmr", 0, 1, B + 8, 0);
    chk("R11 sci", {31'h0, sci}, 0);
    // R1 decode
    acc("R1 wr en", 1, 0, B + 2, 32'h0000_FFFF);
    acc("R1 rd en", 0, 0, B + 2, 0);
    acc("R1 outside", 0, 0, B + 16'h0042, 0);
    acc("R1 outside wr", 1, 0, B + 16'h0042, 32'h0);
    cfg_ctrl = 8'hFE;
    acc("R1 disabled", 0, 0, B + 2, 0);
    acc("R1 disabled wr", 1, 0, B + 2, 0);
    cfg_ctrl = 8'h01;
    acc("R1 en kept", 0, 0, B + 2, 0);
    // R2 aliasing
    acc("R2 alias wr", 1, 0, B + 16'h0012, 32'h0000_0421);
    acc("R4 rd en", 0, 0, B + 16'h0032, 0);
    // R10 width rules
    acc("R10 wide wr", 1, 1, B + 2, 32'hFFFF_FFFF);
    acc("R10 rd en after wide", 0, 0, B + 2, 0);
    acc("R10 wide rd 0", 0, 1, B + 0, 0);
    acc("R10 narrow rd 8", 0, 0, B + 8, 0);
    acc("R10 narrow rd 6", 0, 0, B + 6, 0);
    // R6: event sets status but sci waits for a write
    idle(); evt_rtc = 1; cyc("R6 rtc evt"); idle();
    acc("R3 rtc sts", 0, 0, B + 0, 0);
    chk("R6 sci held", {31'h0, sci}, 0);
    acc("R5 en write", 1, 0, B + 2, 32'h0000_0400);
    chk("R5 sci high", {31'h0, sci}, 1);
    // R3 clear vs set same cycle, then clear
    idle(); io_addr = B; io_wr = 1; io_wdata = 32'h0000_0400; evt_rtc = 1;
    cyc("R3 set wins"); idle();
    acc("R3 still set", 0, 0, B + 0, 0);
    acc("R3 w1c", 1, 0, B + 0, 32'h0000_0400);
    acc("R3 cleared", 0, 0, B + 0, 0);
    chk("R5 sci low", {31'h0, sci}, 0);
    // R7 R8 timer over both top-bit changes
    acc("R8 en tmr", 1, 0, B + 2, 32'h0000_0001);
    for (int i = 0; i < 300; i++) begin
      idle(); tick = 1; cyc("R7 R8 tick");
      if (i % 37 == 0) begin acc("R7 tmr rd", 0, 1, B + 8, 0); acc("R8 sts", 0, 0, B, 0); end
      if (i % 50 == 0) acc("R8 clr", 1, 0, B, 32'h0000_0001);
    end
    // R9 sleep request
    acc("R9 cnt wr", 1, 0, B + 4, 32'h0000_3401);
    chk("R9 req pulse", {31'h0, slp_req}, 1);
    acc("R9 cnt rd", 0, 0, B + 4, 0);
    chk("R9 req gone", {31'h0, slp_req}, 0);
    // randomized mix
    void'($urandom(32'd4242));
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom();
      io_wr = r[0]; io_rd = !r[0]; io_wide = (r[3:1] == 0);
      io_addr = (r[7:4] == 0) ? 16'(r[31:16]) : B + 16'({r[9:8], 1'b0, r[12:10], 1'b0} & 6'h3E);
      io_wdata = $urandom();
      if (r[13]) io_wdata[13] = 0;
      tick = r[14] | r[15];
      evt_rtc = (r[19:16] == 0); evt_pwrbtn = (r[23:20] == 0); evt_gbl = (r[27:24] == 0);
      cfg_ctrl = (r[31:28] == 0) ? 8'h00 : 8'h01;
      cyc("R1 R2 R3 R4 R5 R7 R8 R10 random");
    end
    idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule